// File: doc/BRIEF.md
# Paged Digital I/O Edge-Interrupt Controller

This block manages six 8-bit ports of open-drain digital lines behind an 8-bit register bus. A line is pulled low by writing a 1 to its bit and released by writing a 0, which lets an external pull-up hold it high. A released line can therefore act as an input. Port reads return the inverted level of the synchronised pin, so a high pin reads as 0.

The lowest three ports can also raise edge interrupts. For each line a polarity bit selects the rising or the falling edge, and an enable bit lets that line record an edge. Each recorded edge sets a sticky identification bit. A pending summary register has one bit per interrupt-capable port, and a single interrupt output is high while any identification bit is set.

The polarity, enable and identification bytes share one three-byte window. A page field in a combined page/lock register selects which of them appears there. The same register holds a lock bit for each port, and a set lock bit blocks writes to that port's data. Reads are registered: the value appears on the read data bus one clock after the read strobe.

Top module: `paged_dio_irq`

## Requirements
- R1: After reset every pin_drive_low bit is 0, irq_out is 0, and the page/lock register at 0x17 reads 0x00.
- R2: Writing a byte to offset 0x10+p (p = 0..5) sets pin_drive_low[8p+7:8p] to that byte, so a 1 pulls the line low.
- R3: A read of offset 0x10+p returns the bitwise inverse of the synchronised pin_in[8p+7:8p], whatever page is selected.
- R4: Offset 0x17 holds the page in bits 7:6 (0 none, 1 polarity, 2 enable, 3 identification) and the per-port lock bits in bits 5:0, and it reads back as written.
- R5: While lock bit p is 1, writes to offset 0x10+p leave that port's outputs unchanged.
- R6: Offsets 0x18..0x1A address bytes 0..2 of the bank that the page selects. On page 0 they read 0x00 and ignore writes.
- R7: An enabled line whose polarity bit is 1 latches its identification bit on a low-to-high transition. With a polarity bit of 0 it latches on a high-to-low transition. The bit stays set until it is cleared.
- R8: A line whose enable bit is 0 never sets its identification bit.
- R9: Transitions on lines 24..47 never set an identification bit, a pending bit or irq_out.
- R10: Offset 0x16 returns bit b = OR of identification byte b for b = 0..2, with bits 7:3 at 0. irq_out is the OR of all identification bits.
- R11: Writing an identification byte clears the bits written as 0 and leaves the bits written as 1 unchanged.
- R12: An edge that arrives in the same cycle as a clearing write to its identification byte leaves its bit set.
- R13: Pins pass through two synchronising flops. irq_out rises after the third rising clock edge that follows a qualifying pin change, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; bus_rdata updates on the next edge |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 48 | Sampled levels of the external lines |
| pin_drive_low | output | 48 | 1 pulls the matching line low |
| irq_out | output | 1 | High while any identification bit is set |

## Verification
A corrupted previous-level flop or a wrong synchroniser reset value shows up as a spurious or missing identification bit. Such a fault reaches irq_out and offset 0x16 within three cycles of the pin change, which is why latency is checked cycle by cycle. A wrong page decode shows as the wrong bank's byte, or as a non-zero read on page 0, at the next read of the window. A lost lock or clear mask is visible at pin_drive_low, or at the identification readback, one cycle after the write.

// File: rtl/dio_pg_pkg.sv
package dio_pg_pkg;
   typedef enum logic [1:0] {
      PG_NONE = 2'd0,
      PG_POL  = 2'd1,
      PG_ENA  = 2'd2,
      PG_ID   = 2'd3
   } page_e;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
   parameter int W = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta_q;

   // Reset to the idle level of a pulled-up line so no edge is seen at release
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '1;
         q      <= '1;
      end else begin
         meta_q <= d;
         q      <= meta_q;
      end
   end
endmodule

// File: rtl/dio_edge_latch.sv
module dio_edge_latch #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] en,
   input  logic [W-1:0] keep,
   output logic [W-1:0] id_q
);
   logic [W-1:0] prev_q;
   logic [W-1:0] hit;

   assign hit = en & ((pol & lvl & ~prev_q) | (~pol & ~lvl & prev_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '1;
         id_q   <= '0;
      end else begin
         prev_q <= lvl;
         id_q   <= (id_q & keep) | hit;
      end
   end

   // Edge always lands, even against a clear (R7, R12)
   assert_edge_sets_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> ((id_q & $past(hit)) == $past(hit)));

   // Bits written 0 without an edge are gone next cycle
   assert_clear_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (keep != '1) |=> ((id_q & ~$past(keep) & ~$past(hit)) == '0));

   // A newly set bit must have been enabled
   assert_enable_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((id_q & ~$past(id_q) & ~$past(en)) == '0));
endmodule

// File: rtl/paged_dio_irq.sv
module paged_dio_irq
   import dio_pg_pkg::*;
#(
   parameter int NUM_PORTS = 6,
   parameter int IRQ_PORTS = 3,
   parameter int ADDR_W    = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [7:0]               bus_wdata,
   input  logic                     bus_we,
   input  logic                     bus_re,
   output logic [7:0]               bus_rdata,
   input  logic [NUM_PORTS*8-1:0]   pin_in,
   output logic [NUM_PORTS*8-1:0]   pin_drive_low,
   output logic                     irq_out
);
   localparam int PW        = 8;
   localparam int LINES     = NUM_PORTS * PW;
   localparam int IRQ_LINES = IRQ_PORTS * PW;
   localparam int DATA_BASE = 'h10;
   localparam int PEND_ADDR = 'h16;
   localparam int PAGE_ADDR = 'h17;
   localparam int AUX_BASE  = 'h18;
   localparam int LOCK_W    = 6;

   if (NUM_PORTS < 1 || NUM_PORTS > LOCK_W) begin : g_bad_ports
      $error("NUM_PORTS must be 1..6");
   end
   if (IRQ_PORTS < 1 || IRQ_PORTS > 3 || IRQ_PORTS > NUM_PORTS) begin : g_bad_irq
      $error("IRQ_PORTS must be 1..3 and not above NUM_PORTS");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must be at least 5");
   end

   logic [LINES-1:0]     pin_s;
   logic [PW-1:0]        port_q [NUM_PORTS];
   logic [LOCK_W-1:0]    lock_q;
   page_e                page_q;
   logic [IRQ_LINES-1:0] pol_q, en_q, keep, id_q;
   logic [7:0]           pend;
   logic [7:0]           rd_val;
   logic [7:0]           rdata_q;
   logic                 page_wr;

   dio_sync #(.W(LINES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   assign page_wr = bus_we && (int'(bus_addr) == PAGE_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= PG_NONE;
         lock_q <= '0;
      end else if (page_wr) begin
         page_q <= page_e'(bus_wdata[7:6]);
         lock_q <= bus_wdata[5:0];
      end
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic port_wr;
      assign port_wr = bus_we && (int'(bus_addr) == DATA_BASE + p);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      port_q[p] <= '0;
         else if (port_wr && !lock_q[p])  port_q[p] <= bus_wdata;
      end
      assign pin_drive_low[p*PW +: PW] = port_q[p];

      // Locked port holds its outputs across a data write
      assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (port_wr && lock_q[p]) |=> $stable(pin_drive_low[p*PW +: PW]));
   end

   for (genvar b = 0; b < IRQ_PORTS; b++) begin : g_aux
      logic aux_hit;
      assign aux_hit = bus_we && (int'(bus_addr) == AUX_BASE + b);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pol_q[b*PW +: PW] <= '0;
            en_q[b*PW +: PW]  <= '0;
         end else if (aux_hit) begin
            if (page_q == PG_POL) pol_q[b*PW +: PW] <= bus_wdata;
            if (page_q == PG_ENA) en_q[b*PW +: PW]  <= bus_wdata;
         end
      end
      assign keep[b*PW +: PW] = (aux_hit && page_q == PG_ID) ? bus_wdata : 8'hFF;
   end

   dio_edge_latch #(.W(IRQ_LINES)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (pin_s[IRQ_LINES-1:0]),
      .pol   (pol_q),
      .en    (en_q),
      .keep  (keep),
      .id_q  (id_q)
   );

   always_comb begin
      pend = '0;
      for (int b = 0; b < IRQ_PORTS; b++) pend[b] = |id_q[b*PW +: PW];
   end
   assign irq_out = |id_q;

   always_comb begin
      rd_val = '0;
      for (int p = 0; p < NUM_PORTS; p++)
         if (int'(bus_addr) == DATA_BASE + p) rd_val = ~pin_s[p*PW +: PW];
      for (int b = 0; b < IRQ_PORTS; b++)
         if (int'(bus_addr) == AUX_BASE + b) begin
            case (page_q)
               PG_POL:  rd_val = pol_q[b*PW +: PW];
               PG_ENA:  rd_val = en_q[b*PW +: PW];
               PG_ID:   rd_val = id_q[b*PW +: PW];
               default: rd_val = '0;
            endcase
         end
      if (int'(bus_addr) == PEND_ADDR) rd_val = pend;
      if (int'(bus_addr) == PAGE_ADDR) rd_val = {page_q, lock_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_re) rdata_q <= rd_val;
   end
   assign bus_rdata = rdata_q;

   // Page 0 exposes nothing in the shared window
   assert_page0_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && page_q == PG_NONE && int'(bus_addr) >= AUX_BASE &&
       int'(bus_addr) < AUX_BASE + IRQ_PORTS) |=> (bus_rdata == 8'h00));

   // Interrupt output tracks the pending summary
   assert_irq_summary_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == (pend != 8'h00));
endmodule

// File: tb/paged_dio_irq_test.sv
module paged_dio_irq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [7:0]  bus_rdata;
   logic [47:0] pin_in;
   logic [47:0] pin_drive_low;
   logic        irq_out;
   logic [47:0] ext_low = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;   // 250 MHz

   // open-drain line with pull-up: low if either side pulls
   assign pin_in = ~(pin_drive_low | ext_low);

   paged_dio_irq uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_drive_low(pin_drive_low), .irq_out(irq_out)
   );

   // {port, write data, external pull mask, expected read}
   localparam logic [26:0] VEC [6] = '{
      {3'd0, 8'hA5, 8'h00, 8'hA5},
      {3'd1, 8'h00, 8'h3C, 8'h3C},
      {3'd2, 8'h0F, 8'hF0, 8'hFF},
      {3'd3, 8'h81, 8'h18, 8'h99},
      {3'd4, 8'hFF, 8'h00, 8'hFF},
      {3'd5, 8'h00, 8'h00, 8'h00}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      idle(4);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      check("R1 drive", pin_drive_low, 48'h0);
      check("R1 irq", irq_out, 1'b0);
      rd(5'h17, v); check("R1 page/lock", v, 8'h00);
      rd(5'h18, v); check("R6 page0 blank", v, 8'h00);

      // R2/R3 vector walk
      for (int i = 0; i < 6; i++) begin
         logic [2:0] p;
         p = VEC[i][26:24];
         ext_low[p*8 +: 8] = VEC[i][15:8];
         wr(5'h10 + 5'(p), VEC[i][23:16]);
         check("R2 drive", pin_drive_low[p*8 +: 8], VEC[i][23:16]);
         idle(3);
         rd(5'h10 + 5'(p), v);
         check("R3 inverted read", v, VEC[i][7:0]);
      end
      for (int p = 0; p < 6; p++) wr(5'h10 + 5'(p), 8'h00);
      ext_low = '0;
      idle(5);
      check("R8 no id while disabled", irq_out, 1'b0);

      // R4 / R5 lock
      wr(5'h17, 8'h42);
      rd(5'h17, v); check("R4 readback", v, 8'h42);
      wr(5'h11, 8'hFF);
      check("R5 locked port", pin_drive_low[15:8], 8'h00);
      wr(5'h17, 8'h00);
      wr(5'h18, 8'h77);
      wr(5'h11, 8'h01);
      check("R5 unlocked port", pin_drive_low[15:8], 8'h01);
      wr(5'h11, 8'h00);

      // R6 banks
      wr(5'h17, 8'h40); wr(5'h18, 8'hFF); wr(5'h19, 8'h00);
      wr(5'h17, 8'h80); wr(5'h18, 8'h05); wr(5'h19, 8'h08);
      rd(5'h18, v); check("R6 enable bank", v, 8'h05);
      wr(5'h17, 8'h40);
      rd(5'h18, v); check("R6 polarity bank", v, 8'hFF);
      rd(5'h10, v); check("R3 port read on page1", v, 8'h00);
      idle(5);

      // R7/R13 rising edge on line 0
      ext_low[0] = 1'b1; idle(5);
      check("R7 falling ignored with pol=1", irq_out, 1'b0);
      ext_low[0] = 1'b0;
      idle(2); check("R13 not before third edge", irq_out, 1'b0);
      idle(1); check("R13 third edge", irq_out, 1'b1);
      rd(5'h16, v); check("R10 pending", v, 8'h01);
      wr(5'h17, 8'hC0);
      rd(5'h18, v); check("R7 id byte0", v, 8'h01);

      // R8 disabled line 1
      ext_low[1] = 1'b1; idle(5); ext_low[1] = 1'b0; idle(5);
      rd(5'h18, v); check("R8 disabled line", v, 8'h01);

      // R7 falling on line 11
      ext_low[11] = 1'b1; idle(5);
      rd(5'h19, v); check("R7 falling id", v, 8'h08);
      rd(5'h16, v); check("R10 pending two", v, 8'h03);

      // R9 upper ports
      ext_low[24] = 1'b1; ext_low[40] = 1'b1; idle(5);
      ext_low[24] = 1'b0; ext_low[40] = 1'b0; idle(5);
      rd(5'h16, v); check("R9 upper lines silent", v, 8'h03);

      // R11 clear masks
      wr(5'h18, 8'hFF);
      rd(5'h18, v); check("R11 ones keep", v, 8'h01);
      wr(5'h19, 8'h00);
      rd(5'h16, v); check("R11 clear byte1", v, 8'h01);
      wr(5'h18, 8'h00);
      check("R11 irq cleared", irq_out, 1'b0);
      ext_low[11] = 1'b0; idle(5);

      // R12 edge against clear: preset line 0, arm line 2
      ext_low[0] = 1'b1; idle(5); ext_low[0] = 1'b0; idle(5);
      ext_low[2] = 1'b1; idle(5);
      rd(5'h18, v); check("R12 preset", v, 8'h01);
      @(negedge clk); ext_low[2] = 1'b0;
      @(negedge clk);
      @(negedge clk); bus_addr = 5'h18; bus_wdata = 8'h00; bus_we = 1'b1;
      @(negedge clk); bus_we = 1'b0;
      rd(5'h18, v); check("R12 edge wins", v, 8'h04);
      check("R10 irq with id", irq_out, 1'b1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule